// File: doc/BRIEF.md
# Banked UART Control Register File

This block is the register front end of a 16550-style serial port that carries a set of extended control registers. A simple bus drives it with one read or write per cycle. Registers sit on word-spaced byte addresses: the register index is the byte address shifted right by two. The same index reaches different physical registers depending on the access bank. The value held in the line control register selects that bank, and there are three of them: operational, configuration A and configuration B.

The block holds the divisor bytes, the extended feature register, the supplementary control register, the trigger-level register, the mode register and the FIFO control fields. It drives these straight to the serial datapath as registered outputs. In operational bank, the data index also produces one-cycle push and pop strobes toward the transmit and receive FIFOs. Reads return one cycle after the request. Software normally disables the port through the mode register, loads the divisor and format in a configuration bank, and then returns to the operational bank.

Top module: `uart_bank_regfile`

## Requirements
- R1: Register index = bus_addr >> 2. An access whose two low address bits are not zero is unmapped: a read returns 0x00 and a write changes nothing.
- R2: The bank is set by the line control register (index 3), which is readable and writable in every bank. Bit 7 clear selects operational. The value 0xBF selects configuration B. Any other value with bit 7 set selects configuration A.
- R3: Indexes 0 and 1 are the transmit/receive data port and the interrupt enable in operational bank, and the divisor low and high bytes in both configuration banks. Index 2 is the FIFO control (write-only, reads 0x00) in operational and configuration A, and the extended feature register (read/write) in configuration B.
- R4: The modem control register (index 4) is reachable in operational and configuration A. In configuration B it reads 0x00 and writes to it are ignored.
- R5: Interrupt enable bits 7:4 and modem control bit 6 take written values only while extended feature bit 4 is 1. Otherwise those bits keep their value and the other bits are still written.
- R6: The trigger-level register (index 7, output trig_lvl) is reachable only while modem control bit 6 and extended feature bit 4 are both 1. Otherwise it reads 0x00 and writes are ignored.
- R7: divisor = {high byte, low byte}. Divisor writes take effect only while the mode register holds 0x7. Otherwise they are ignored.
- R8: The mode register (index 8, 3 bits) resets to 0x7, which means disabled. uart_en is 1 exactly when it holds 0x0.
- R9: A FIFO control write sets fifo_en from bit 0, tx_trig from bits 5:4 and rx_trig from bits 7:6. Bits 1 and 2 give one-cycle pulses on rx_flush and tx_flush in the next cycle and are not stored.
- R10: The supplementary control register (index 16) drives rx_gran1 from its bit 7. Line control bits 1:0, 2, 5:3 and 6 drive char_len, stop_sel, parity_ctl and break_ctl.
- R11: A read request returns bus_rvalid = 1 with bus_rdata in the next cycle. Unmapped reads return 0x00.
- R12: When a read and a write to the same address share a cycle, the read returns the value from before the write and is decoded in the bank from before the write.
- R13: In operational bank, a write to index 0 gives tx_push = 1 with tx_data in the next cycle. A read of index 0 returns rx_data as sampled at the request and pulses rx_pop in the next cycle.
- R14: After reset all registers are 0x00 except the mode register (0x7). The bank is operational and every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| rx_data | input | 8 | Head of receive FIFO |
| rx_pop | output | 1 | Pop receive FIFO |
| tx_push | output | 1 | Push transmit FIFO |
| tx_data | output | 8 | Byte to push |
| divisor | output | 16 | Baud divisor |
| char_len | output | 2 | Character length minus five |
| stop_sel | output | 1 | Stop-bit select |
| parity_ctl | output | 3 | Parity control |
| break_ctl | output | 1 | Break control |
| int_en | output | 8 | Interrupt enables |
| modem_ctl | output | 8 | Modem control |
| fifo_en | output | 1 | FIFO enable |
| rx_trig | output | 2 | Receive trigger code |
| tx_trig | output | 2 | Transmit trigger code |
| rx_flush | output | 1 | Receive FIFO clear pulse |
| tx_flush | output | 1 | Transmit FIFO clear pulse |
| rx_gran1 | output | 1 | Single-character receive trigger granularity |
| trig_lvl | output | 8 | Trigger-level register |
| op_mode_sel | output | 3 | Mode register value |
| uart_en | output | 1 | Port enabled (16x mode) |

## Verification
A read and a write may land in the same cycle at the same address. The bench provokes this at the line control index, writing the bank key while reading. The read must still return the old value, and a following read must show the new bank in force. The bench repeats the case at index 2 in configuration B, where the extended feature register is read while it is being cleared. The scoreboard holds the pre-write value as the expected item and judges the collision by it.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  typedef enum logic [1:0] {
    BANK_OP  = 2'd0,
    BANK_CFA = 2'd1,
    BANK_CFB = 2'd2
  } bank_e;

  localparam logic [7:0] CFB_KEY     = 8'hBF;
  localparam logic [2:0] MODE_OFF    = 3'd7;
  localparam int         EXT_BIT     = 4;
  localparam int         MCR_TLR_BIT = 6;

  localparam int IX_DATA = 0;
  localparam int IX_IER  = 1;
  localparam int IX_FCR  = 2;
  localparam int IX_LCR  = 3;
  localparam int IX_MCR  = 4;
  localparam int IX_TLR  = 7;
  localparam int IX_MDR  = 8;
  localparam int IX_SCR  = 16;
endpackage

// File: rtl/ubr_addr_decode.sv
module ubr_addr_decode #(
  parameter int ADDR_W    = 7,
  parameter int REG_SHIFT = 2,
  localparam int IDX_W    = ADDR_W - REG_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              aligned,
  output logic [IDX_W-1:0]  idx
);
  assign aligned = (addr[REG_SHIFT-1:0] == '0);
  assign idx     = addr[ADDR_W-1:REG_SHIFT];
endmodule

// File: rtl/ubr_bank_select.sv
module ubr_bank_select
  import ubr_pkg::*;
(
  input  logic [7:0] lcr,
  input  logic [7:0] efr,
  input  logic [7:0] mcr,
  output bank_e      bank,
  output logic       tlr_open
);
  always_comb begin
    if (!lcr[7])             bank = BANK_OP;
    else if (lcr == CFB_KEY) bank = BANK_CFB;
    else                     bank = BANK_CFA;
  end

  assign tlr_open = efr[EXT_BIT] & mcr[MCR_TLR_BIT];
endmodule

// File: rtl/ubr_reg_bank.sv
module ubr_reg_bank
  import ubr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  input  bank_e            bank,
  input  logic             tlr_open,
  output logic [7:0]       lcr_q,
  output logic [7:0]       ier_q,
  output logic [7:0]       mcr_q,
  output logic [7:0]       efr_q,
  output logic [7:0]       dll_q,
  output logic [7:0]       dlh_q,
  output logic [7:0]       scr_q,
  output logic [7:0]       tlr_q,
  output logic [2:0]       mdr_q,
  output logic             fifo_en_q,
  output logic [1:0]       rx_trig_q,
  output logic [1:0]       tx_trig_q,
  output logic             rx_flush_q,
  output logic             tx_flush_q,
  output logic             tx_push_q,
  output logic [7:0]       tx_data_q
);
  logic ext_on;
  logic div_open;
  assign ext_on   = efr_q[EXT_BIT];
  assign div_open = (mdr_q == MODE_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q      <= '0;
      ier_q      <= '0;
      mcr_q      <= '0;
      efr_q      <= '0;
      dll_q      <= '0;
      dlh_q      <= '0;
      scr_q      <= '0;
      tlr_q      <= '0;
      mdr_q      <= MODE_OFF;
      fifo_en_q  <= 1'b0;
      rx_trig_q  <= '0;
      tx_trig_q  <= '0;
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
      tx_push_q  <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
      tx_push_q  <= 1'b0;
      if (wr_en) begin
        case (int'(idx))
          IX_DATA: begin
            if (bank == BANK_OP) begin
              tx_push_q <= 1'b1;
              tx_data_q <= wdata;
            end else if (div_open) begin
              dll_q <= wdata;
            end
          end
          IX_IER: begin
            if (bank == BANK_OP)
              ier_q <= {(ext_on ? wdata[7:4] : ier_q[7:4]), wdata[3:0]};
            else if (div_open)
              dlh_q <= wdata;
          end
          IX_FCR: begin
            if (bank == BANK_CFB) begin
              efr_q <= wdata;
            end else begin
              fifo_en_q  <= wdata[0];
              rx_flush_q <= wdata[1];
              tx_flush_q <= wdata[2];
              tx_trig_q  <= wdata[5:4];
              rx_trig_q  <= wdata[7:6];
            end
          end
          IX_LCR: lcr_q <= wdata;
          IX_MCR: begin
            if (bank != BANK_CFB)
              mcr_q <= {wdata[7], (ext_on ? wdata[6] : mcr_q[6]), wdata[5:0]};
          end
          IX_TLR: begin
            if (tlr_open) tlr_q <= wdata;
          end
          IX_MDR: mdr_q <= wdata[2:0];
          IX_SCR: scr_q <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ubr_read_mux.sv
module ubr_read_mux
  import ubr_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic             aligned,
  input  logic [IDX_W-1:0] idx,
  input  bank_e            bank,
  input  logic             tlr_open,
  input  logic [7:0]       rx_data,
  input  logic [7:0]       lcr_q,
  input  logic [7:0]       ier_q,
  input  logic [7:0]       mcr_q,
  input  logic [7:0]       efr_q,
  input  logic [7:0]       dll_q,
  input  logic [7:0]       dlh_q,
  input  logic [7:0]       scr_q,
  input  logic [7:0]       tlr_q,
  input  logic [2:0]       mdr_q,
  output logic [7:0]       rdata_q,
  output logic             rvalid_q,
  output logic             rx_pop_q
);
  logic [7:0] sel;
  logic       pop_hit;

  always_comb begin
    sel     = '0;
    pop_hit = 1'b0;
    if (aligned) begin
      case (int'(idx))
        IX_DATA: begin
          if (bank == BANK_OP) begin
            sel     = rx_data;
            pop_hit = 1'b1;
          end else begin
            sel = dll_q;
          end
        end
        IX_IER:  sel = (bank == BANK_OP) ? ier_q : dlh_q;
        IX_FCR:  sel = (bank == BANK_CFB) ? efr_q : 8'h00;
        IX_LCR:  sel = lcr_q;
        IX_MCR:  sel = (bank != BANK_CFB) ? mcr_q : 8'h00;
        IX_TLR:  sel = tlr_open ? tlr_q : 8'h00;
        IX_MDR:  sel = {5'b0, mdr_q};
        IX_SCR:  sel = scr_q;
        default: sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      rx_pop_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      rx_pop_q <= rd_req & pop_hit;
      rdata_q  <= rd_req ? sel : 8'h00;
    end
  end
endmodule

// File: rtl/uart_bank_regfile.sv
module uart_bank_regfile
  import ubr_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int REG_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  output logic [15:0]       divisor,
  output logic [1:0]        char_len,
  output logic              stop_sel,
  output logic [2:0]        parity_ctl,
  output logic              break_ctl,
  output logic [7:0]        int_en,
  output logic [7:0]        modem_ctl,
  output logic              fifo_en,
  output logic [1:0]        rx_trig,
  output logic [1:0]        tx_trig,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic              rx_gran1,
  output logic [7:0]        trig_lvl,
  output logic [2:0]        op_mode_sel,
  output logic              uart_en
);
  localparam int IDX_W = ADDR_W - REG_SHIFT;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  bank_e            bank;
  logic             tlr_open;
  logic [7:0]       lcr_w, ier_w, mcr_w, efr_w, dll_w, dlh_w, scr_w, tlr_w;
  logic [2:0]       mdr_w;

  ubr_addr_decode #(.ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT)) u_dec (
    .addr(bus_addr), .aligned(aligned), .idx(idx)
  );

  ubr_bank_select u_bank_sel (
    .lcr(lcr_w), .efr(efr_w), .mcr(mcr_w), .bank(bank), .tlr_open(tlr_open)
  );

  ubr_reg_bank #(.IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bus_wr & aligned), .idx(idx),
    .wdata(bus_wdata), .bank(bank), .tlr_open(tlr_open),
    .lcr_q(lcr_w), .ier_q(ier_w), .mcr_q(mcr_w), .efr_q(efr_w),
    .dll_q(dll_w), .dlh_q(dlh_w), .scr_q(scr_w), .tlr_q(tlr_w),
    .mdr_q(mdr_w), .fifo_en_q(fifo_en), .rx_trig_q(rx_trig),
    .tx_trig_q(tx_trig), .rx_flush_q(rx_flush), .tx_flush_q(tx_flush),
    .tx_push_q(tx_push), .tx_data_q(tx_data)
  );

  ubr_read_mux #(.IDX_W(IDX_W)) u_rmux (
    .clk(clk), .rst(rst), .rd_req(bus_rd), .aligned(aligned), .idx(idx),
    .bank(bank), .tlr_open(tlr_open), .rx_data(rx_data),
    .lcr_q(lcr_w), .ier_q(ier_w), .mcr_q(mcr_w), .efr_q(efr_w),
    .dll_q(dll_w), .dlh_q(dlh_w), .scr_q(scr_w), .tlr_q(tlr_w),
    .mdr_q(mdr_w), .rdata_q(bus_rdata), .rvalid_q(bus_rvalid),
    .rx_pop_q(rx_pop)
  );

  assign divisor     = {dlh_w, dll_w};
  assign char_len    = lcr_w[1:0];
  assign stop_sel    = lcr_w[2];
  assign parity_ctl  = lcr_w[5:3];
  assign break_ctl   = lcr_w[6];
  assign int_en      = ier_w;
  assign modem_ctl   = mcr_w;
  assign rx_gran1    = scr_w[7];
  assign trig_lvl    = tlr_w;
  assign op_mode_sel = mdr_w;
  assign uart_en     = (mdr_w == 3'd0);
endmodule

// File: rtl/ubr_checker.sv
module ubr_checker #(
  parameter int ADDR_W    = 7,
  parameter int REG_SHIFT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              bus_rvalid,
  input logic              rx_flush,
  input logic              tx_flush,
  input logic              tx_push,
  input logic              rx_pop,
  input logic [15:0]       divisor,
  input logic [2:0]        op_mode_sel,
  input logic [7:0]        efr_q,
  input logic [7:0]        int_en
);
  p_rvalid_follows_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_rvalid_needs_rd_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));
  p_unaligned_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr[REG_SHIFT-1:0] != '0)) |=> (bus_rdata == 8'h00));
  p_div_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (op_mode_sel != 3'd7) |=> $stable(divisor));
  p_ext_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !efr_q[4] |=> $stable(int_en[7:4]));
  p_flush_src_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_flush || tx_flush) |-> $past(bus_wr));
  p_push_src_r13: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(bus_wr));
  p_pop_src_r13: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(bus_rd));
endmodule

bind uart_bank_regfile ubr_checker #(.ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .rx_flush(rx_flush),
  .tx_flush(tx_flush), .tx_push(tx_push), .rx_pop(rx_pop), .divisor(divisor),
  .op_mode_sel(op_mode_sel), .efr_q(efr_w), .int_en(int_en)
);

// File: tb/tb_uart_bank_regfile.sv
module tb_uart_bank_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  rx_data = 8'hC3;
  logic        rx_pop, tx_push;
  logic [7:0]  tx_data;
  logic [15:0] divisor;
  logic [1:0]  char_len;
  logic        stop_sel;
  logic [2:0]  parity_ctl;
  logic        break_ctl;
  logic [7:0]  int_en, modem_ctl;
  logic        fifo_en;
  logic [1:0]  rx_trig, tx_trig;
  logic        rx_flush, tx_flush, rx_gran1;
  logic [7:0]  trig_lvl;
  logic [2:0]  op_mode_sel;
  logic        uart_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  uart_bank_regfile dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_data(rx_data), .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data),
    .divisor(divisor), .char_len(char_len), .stop_sel(stop_sel),
    .parity_ctl(parity_ctl), .break_ctl(break_ctl), .int_en(int_en),
    .modem_ctl(modem_ctl), .fifo_en(fifo_en), .rx_trig(rx_trig),
    .tx_trig(tx_trig), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .rx_gran1(rx_gran1), .trig_lvl(trig_lvl), .op_mode_sel(op_mode_sel),
    .uart_en(uart_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdwr(input logic [6:0] a, input logic [7:0] d, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && bus_rvalid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11: actual unexpected read expected none");
        end else begin
          chk(tag_q.pop_front(), {24'b0, bus_rdata}, {24'b0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R14 reset state
    chk("R14 divisor", divisor, 16'h0);
    chk("R14 mode reg", op_mode_sel, 3'd7);
    chk("R8 uart_en off", uart_en, 0);
    chk("R14 strobes", {tx_push, rx_pop, rx_flush, tx_flush}, 4'b0);
    rd(7'd12, 8'h00, "R14 lcr reset");
    rd(7'd32, 8'h07, "R8 mode reset read");

    // Operational bank, extended bit clear
    wr(7'd4, 8'hFF);
    chk("R5 ier upper gated", int_en, 8'h0F);
    rd(7'd4, 8'h0F, "R3 ier read op");
    wr(7'd0, 8'h5A);
    chk("R13 tx_push", tx_push, 1);
    chk("R13 tx_data", tx_data, 8'h5A);
    @(negedge clk);
    chk("R13 tx_push one cycle", tx_push, 0);
    rd(7'd0, 8'hC3, "R13 rx read");
    chk("R13 rx_pop", rx_pop, 1);
    rd(7'd5, 8'h00, "R1 unaligned read");
    wr(7'd13, 8'hBF);
    rd(7'd12, 8'h00, "R1 unaligned write ignored");

    // Configuration A
    wr(7'd12, 8'h80);
    wr(7'd0, 8'h34);
    wr(7'd4, 8'h12);
    chk("R7 divisor load", divisor, 16'h1234);
    chk("R3 ier untouched by dlh", int_en, 8'h0F);
    rd(7'd0, 8'h34, "R3 dll read");
    rd(7'd4, 8'h12, "R3 dlh read");
    rd(7'd8, 8'h00, "R3 fcr reads zero");
    wr(7'd16, 8'h43);
    chk("R5 mcr bit6 gated", modem_ctl, 8'h03);
    rd(7'd28, 8'h00, "R6 tlr closed");

    // Configuration B
    wr(7'd12, 8'hBF);
    rd(7'd16, 8'h00, "R4 mcr hidden in B");
    wr(7'd16, 8'h00);
    chk("R4 mcr write ignored in B", modem_ctl, 8'h03);
    wr(7'd8, 8'h10);
    rd(7'd8, 8'h10, "R3 efr read");
    chk("R3 fifo untouched by efr", fifo_en, 0);

    // Back to A with extended bit set
    wr(7'd12, 8'h80);
    wr(7'd16, 8'h43);
    chk("R5 mcr bit6 open", modem_ctl, 8'h43);
    wr(7'd28, 8'h9A);
    chk("R6 tlr write", trig_lvl, 8'h9A);
    rd(7'd28, 8'h9A, "R6 tlr read");
    wr(7'd8, 8'h67);
    chk("R9 flush pulses", {rx_flush, tx_flush}, 2'b11);
    chk("R9 fifo fields", {fifo_en, rx_trig, tx_trig}, {1'b1, 2'b01, 2'b10});
    @(negedge clk);
    chk("R9 flush one cycle", {rx_flush, tx_flush}, 2'b00);
    wr(7'd16, 8'h03);
    rd(7'd28, 8'h00, "R6 tlr closed by mcr");
    wr(7'd28, 8'h11);
    chk("R6 tlr write ignored", trig_lvl, 8'h9A);

    // Mode register, divisor lock
    wr(7'd32, 8'h00);
    chk("R8 uart_en on", uart_en, 1);
    wr(7'd0, 8'hFF);
    chk("R7 divisor locked", divisor, 16'h1234);
    rd(7'd32, 8'h00, "R8 mode read");
    wr(7'd64, 8'h80);
    chk("R10 rx_gran1", rx_gran1, 1);
    rd(7'd64, 8'h80, "R10 scr read");

    // Operational with frame format
    wr(7'd12, 8'h1F);
    chk("R10 frame", {break_ctl, parity_ctl, stop_sel, char_len}, {1'b0, 3'b011, 1'b1, 2'b11});
    chk("R2 op bank tx", tx_push, 0);
    wr(7'd4, 8'hF5);
    chk("R5 ier upper open", int_en, 8'hF5);

    // R12 collisions
    rdwr(7'd12, 8'hBF, 8'h1F, "R12 lcr read old");
    rd(7'd12, 8'hBF, "R2 lcr new");
    rd(7'd4, 8'h12, "R2 bank B dlh");
    rdwr(7'd8, 8'h00, 8'h10, "R12 efr read old");
    rd(7'd8, 8'h00, "R12 efr cleared");

    repeat (3) @(negedge clk);
    chk("R11 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule